// File: doc/BRIEF.md
# Serial EEPROM Read Sequencer

This block reads a run of consecutive bytes from a serial configuration EEPROM. It drives the clock and data lines one step at a time instead of using a free-running serial clock. A request supplies a 16-bit start offset and a byte count. The engine checks that a device is present and that the configured base offset fits in 16 bits. It then claims the bus through an ordered pair of access-control pins and sends a read command followed by the two address bytes. After that it clocks in the requested bytes and hands each one over on a valid/ready output stream. Last, it gives the bus back in the reverse order.

Every step of the pin sequence lasts a number of core clock cycles set by `step_div_i`. A step is one of: enable edge, data set-up, clock high, clock low or release edge. This sets the serial clock rate. The stream follows the usual rules. `m_valid_o` stays high and `m_data_o` holds still until a cycle with `m_ready_i` high. While a byte waits for the consumer, the serial clock is paused low. Back-pressure therefore stretches the transfer but never loses a bit.

Top module: `eeprom_bitbang_reader`

## Requirements
- R1: Out of reset, `sclk_o`=0, `grant_hi_o`=0, `grant_lo_o`=1, `busy_o`=0, `error_o`=0 and `m_valid_o`=0.
- R2: Claiming the bus raises `grant_hi_o` while `grant_lo_o` is still 1, and only one step later lowers `grant_lo_o`. Releasing raises `grant_lo_o` while `grant_hi_o` is still 1, and one step later lowers `grant_hi_o`. Every accepted request ends with the release.
- R3: `sclk_o` is high only while the bus is claimed (`grant_hi_o`=1 and `grant_lo_o`=0).
- R4: Each outgoing bit is placed on `sdo_o` one step before `sclk_o` rises, and it does not change while `sclk_o` is high.
- R5: The outgoing frame is the byte 0x03, then address bits 15:8, then address bits 7:0, each sent most significant bit first. The address is (`base_i[15:0]` + `offset_i`) modulo 65536.
- R6: Incoming bits are sampled from `sdi_i` at the end of the clock-high step, most significant bit first. Byte i of the stream is the device byte at address + i.
- R7: Each step lasts `step_div_i`+1 core cycles. An outgoing bit therefore takes 3 steps (set, high, low) and an incoming bit takes 2 steps (high, low).
- R8: While `m_valid_o`=1 and `m_ready_i`=0, `m_valid_o` stays 1, `m_data_o` is unchanged and no serial clock edge occurs.
- R9: Exactly `count_i` bytes are delivered. A count of zero still claims the bus, sends the 24-bit frame and releases the bus, with no stream output.
- R10: `busy_o` rises together with `grant_hi_o` when a request is accepted. It falls one step after `grant_hi_o` falls. Whenever `busy_o` is 0, the bus pins are released, `sclk_o` is 0 and `m_valid_o` is 0.
- R11: `start_i` has no effect while `busy_o` is 1.
- R12: A start is refused, with `error_o` set to 1 and no pin activity, when `dev_present_i`=0, or `dev_absent_i`=1, or `base_i` exceeds 0xFFFF. `error_o` stays set until a later request is accepted, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse, sampled only while idle |
| offset_i | input | 16 | Start offset relative to the base |
| count_i | input | CNT_W | Number of bytes to read |
| base_i | input | BASE_W | Configured base offset of the data region |
| dev_present_i | input | 1 | Device-present indication |
| dev_absent_i | input | 1 | Device-not-present indication |
| step_div_i | input | DIV_W | Step length minus one, in core cycles |
| sclk_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data to the device |
| sdi_i | input | 1 | Serial data from the device |
| grant_hi_o | output | 1 | Access control, active high |
| grant_lo_o | output | 1 | Access control, active low |
| m_valid_o | output | 1 | Stream byte valid |
| m_data_o | output | 8 | Stream byte |
| m_ready_i | input | 1 | Stream consumer ready |
| busy_o | output | 1 | Request in progress |
| error_o | output | 1 | Last start was refused |

## Verification
The hardest case to reach is a consumer that stalls mid-transfer. In that case the serial clock must freeze with its level low and the held byte must stay intact while the device model keeps driving data. The bench holds `m_ready_i` low for forty cycles on the first delivered byte. Across the stall it compares the serial clock edge count and the held data. It then checks that the remaining bytes still arrive in order.

A second case that is hard to reach is a new start arriving in the middle of a transfer. The bench pulses `start_i` with a different offset and count partway through a read. It then confirms that the captured address and the delivered bytes belong to the original request.

// File: rtl/eerd_pkg.sv
`timescale 1ns/1ps
package eerd_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 16;
  localparam int BIT_CW = $clog2(BYTE_W);
  localparam logic [BYTE_W-1:0] CMD_READ = 8'h03;
  localparam int FRAME_BYTES = 3;

  typedef enum logic [3:0] {
    S_IDLE,
    S_EN_HI,
    S_EN_LO,
    S_TX_SET,
    S_TX_RISE,
    S_TX_FALL,
    S_RX_RISE,
    S_RX_FALL,
    S_DELIVER,
    S_DIS_LO,
    S_DIS_HI
  } eerd_state_e;
endpackage

// File: rtl/eerd_step_timer.sv
`timescale 1ns/1ps
module eerd_step_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - W'(1);
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/eerd_shifter.sv
`timescale 1ns/1ps
module eerd_shifter
  import eerd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_load,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              tx_shift,
  input  logic              rx_shift,
  input  logic              sdi,
  output logic              tx_msb,
  output logic [BYTE_W-1:0] rx_byte
);
  logic [BYTE_W-1:0] tx_q, rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (tx_load)       tx_q <= tx_byte;
      else if (tx_shift) tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
      if (rx_shift)      rx_q <= {rx_q[BYTE_W-2:0], sdi};
    end
  end

  assign tx_msb  = tx_q[BYTE_W-1];
  assign rx_byte = rx_q;
endmodule

// File: rtl/eeprom_bitbang_reader.sv
`timescale 1ns/1ps
module eeprom_bitbang_reader
  import eerd_pkg::*;
#(
  parameter int CNT_W  = 11,
  parameter int DIV_W  = 8,
  parameter int BASE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [15:0]       offset_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic              dev_present_i,
  input  logic              dev_absent_i,
  input  logic [DIV_W-1:0]  step_div_i,
  output logic              sclk_o,
  output logic              sdo_o,
  input  logic              sdi_i,
  output logic              grant_hi_o,
  output logic              grant_lo_o,
  output logic              m_valid_o,
  output logic [7:0]        m_data_o,
  input  logic              m_ready_i,
  output logic              busy_o,
  output logic              error_o
);
  localparam int LAST_IDX = FRAME_BYTES - 1;

  eerd_state_e state_q, nxt;
  logic [BIT_CW-1:0] bit_q;
  logic [1:0]        tx_idx_q;
  logic [CNT_W-1:0]  left_q;
  logic [ADDR_W-1:0] addr_q;
  logic              step_done, step_load, bit_last, fault, accept;
  logic              tx_load, tx_shift, rx_shift;
  logic [BYTE_W-1:0] tx_byte;

  assign fault    = !dev_present_i || dev_absent_i || (|base_i[BASE_W-1:ADDR_W]);
  assign bit_last = (bit_q == BIT_CW'(BYTE_W - 1));
  assign tx_byte  = (state_q == S_EN_HI) ? CMD_READ :
                    (tx_idx_q == 2'd0)   ? addr_q[15:8] : addr_q[7:0];

  always_comb begin
    nxt      = state_q;
    accept   = 1'b0;
    tx_load  = 1'b0;
    tx_shift = 1'b0;
    rx_shift = 1'b0;
    unique case (state_q)
      S_IDLE:    if (start_i && !fault) begin nxt = S_EN_HI; accept = 1'b1; end
      S_EN_HI:   if (step_done) begin nxt = S_EN_LO; tx_load = 1'b1; end
      S_EN_LO:   if (step_done) nxt = S_TX_SET;
      S_TX_SET:  if (step_done) nxt = S_TX_RISE;
      S_TX_RISE: if (step_done) nxt = S_TX_FALL;
      S_TX_FALL: if (step_done) begin
        if (!bit_last) begin
          tx_shift = 1'b1;
          nxt      = S_TX_SET;
        end else if (tx_idx_q != 2'(LAST_IDX)) begin
          tx_load = 1'b1;
          nxt     = S_TX_SET;
        end else begin
          nxt = (left_q == '0) ? S_DIS_LO : S_RX_RISE;
        end
      end
      S_RX_RISE: if (step_done) begin rx_shift = 1'b1; nxt = S_RX_FALL; end
      S_RX_FALL: if (step_done) nxt = bit_last ? S_DELIVER : S_RX_RISE;
      S_DELIVER: if (m_ready_i) nxt = (left_q == CNT_W'(1)) ? S_DIS_LO : S_RX_RISE;
      S_DIS_LO:  if (step_done) nxt = S_DIS_HI;
      S_DIS_HI:  if (step_done) nxt = S_IDLE;
      default:   nxt = S_IDLE;
    endcase
  end

  assign step_load = (nxt != state_q);

  eerd_step_timer #(.W(DIV_W)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (step_load),
    .load_val (step_div_i),
    .done     (step_done)
  );

  eerd_shifter shifter_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_load  (tx_load),
    .tx_byte  (tx_byte),
    .tx_shift (tx_shift),
    .rx_shift (rx_shift),
    .sdi      (sdi_i),
    .tx_msb   (sdo_o),
    .rx_byte  (m_data_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      bit_q      <= '0;
      tx_idx_q   <= '0;
      left_q     <= '0;
      addr_q     <= '0;
      error_o    <= 1'b0;
      sclk_o     <= 1'b0;
      grant_hi_o <= 1'b0;
      grant_lo_o <= 1'b1;
      busy_o     <= 1'b0;
      m_valid_o  <= 1'b0;
    end else begin
      state_q <= nxt;
      if (accept) begin
        bit_q    <= '0;
        tx_idx_q <= '0;
        left_q   <= count_i;
        addr_q   <= base_i[ADDR_W-1:0] + offset_i;
        error_o  <= 1'b0;
      end else if (state_q == S_IDLE && start_i) begin
        error_o <= 1'b1;
      end
      if (step_done && (state_q == S_TX_FALL || state_q == S_RX_FALL))
        bit_q <= bit_q + BIT_CW'(1);
      if (state_q == S_TX_FALL && step_done && bit_last && tx_idx_q != 2'(LAST_IDX))
        tx_idx_q <= tx_idx_q + 2'd1;
      if (state_q == S_DELIVER && m_ready_i)
        left_q <= left_q - CNT_W'(1);
      sclk_o     <= (nxt == S_TX_RISE) || (nxt == S_RX_RISE);
      grant_hi_o <= (nxt != S_IDLE) && (nxt != S_DIS_HI);
      grant_lo_o <= (nxt == S_IDLE) || (nxt == S_EN_HI) ||
                    (nxt == S_DIS_LO) || (nxt == S_DIS_HI);
      busy_o     <= (nxt != S_IDLE);
      m_valid_o  <= (nxt == S_DELIVER);
    end
  end
endmodule

// File: rtl/eerd_checker.sv
`timescale 1ns/1ps
module eerd_checker #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sclk_o,
  input logic             sdo_o,
  input logic             grant_hi_o,
  input logic             grant_lo_o,
  input logic             m_valid_o,
  input logic [7:0]       m_data_o,
  input logic             m_ready_i,
  input logic             busy_o,
  input logic             error_o,
  input logic [DIV_W-1:0] step_div_i
);
  localparam int HW = DIV_W + 1;
  logic [HW-1:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hi_len <= '0;
    else if (sclk_o) hi_len <= hi_len + HW'(1);
    else             hi_len <= '0;
  end

  assert_claim_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_hi_o) |-> grant_lo_o);
  assert_claim_second_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(grant_lo_o) |-> grant_hi_o && $past(grant_hi_o));
  assert_release_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_lo_o) |-> grant_hi_o);
  assert_release_second_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(grant_hi_o) |-> grant_lo_o && $past(grant_lo_o));
  assert_clock_in_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> grant_hi_o && !grant_lo_o);
  assert_data_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> $stable(sdo_o));
  assert_high_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_o) |-> hi_len == (HW'(step_div_i) + HW'(1)));
  assert_hold_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid_o && !m_ready_i |=> m_valid_o && $stable(m_data_o));
  assert_clock_paused_R8: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid_o |-> !sclk_o);
  assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> grant_hi_o && grant_lo_o);
  assert_idle_pins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !grant_hi_o && grant_lo_o && !sclk_o && !m_valid_o);
  assert_error_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |-> !busy_o);
endmodule

bind eeprom_bitbang_reader eerd_checker #(.DIV_W(DIV_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .sclk_o     (sclk_o),
  .sdo_o      (sdo_o),
  .grant_hi_o (grant_hi_o),
  .grant_lo_o (grant_lo_o),
  .m_valid_o  (m_valid_o),
  .m_data_o   (m_data_o),
  .m_ready_i  (m_ready_i),
  .busy_o     (busy_o),
  .error_o    (error_o),
  .step_div_i (step_div_i)
);

// File: tb/eeprom_bitbang_reader_tb.sv
`timescale 1ns/1ps
module eeprom_bitbang_reader_tb_top;
  localparam int CNT_W = 11;
  localparam int DIV_W = 8;
  localparam int NV    = 5;

  localparam logic [31:0] V_BASE [NV] = '{32'h0000_0000, 32'h0000_0100, 32'h0000_0010, 32'h0000_F000, 32'h0000_0001};
  localparam logic [15:0] V_OFF  [NV] = '{16'h0000, 16'h1234, 16'hFFFE, 16'h00FF, 16'h8001};
  localparam int          V_CNT  [NV] = '{3, 4, 4, 1, 5};
  localparam int          V_DIV  [NV] = '{0, 1, 2, 3, 0};
  localparam int          V_MODE [NV] = '{0, 1, 0, 1, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [15:0] offset_i = '0;
  logic [CNT_W-1:0] count_i = '0;
  logic [31:0] base_i = '0;
  logic dev_present_i = 1'b1;
  logic dev_absent_i = 1'b0;
  logic [DIV_W-1:0] step_div_i = '0;
  logic sdi_i = 1'b0;
  logic m_ready_i = 1'b0;
  logic sclk_o, sdo_o, grant_hi_o, grant_lo_o, m_valid_o, busy_o, error_o;
  logic [7:0] m_data_o;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int rise_cnt = 0, hi_rises = 0, viol = 0, viol4 = 0;
  int t_r0 = 0, t_r1 = 0, t_r24 = 0, t_r25 = 0, nbytes = 0;
  logic [23:0] cap = '0;
  logic sdo_at_rise = 1'b0;
  logic [7:0] rx_bytes [16];

  eeprom_bitbang_reader #(.CNT_W(CNT_W), .DIV_W(DIV_W), .BASE_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .offset_i(offset_i),
    .count_i(count_i), .base_i(base_i), .dev_present_i(dev_present_i),
    .dev_absent_i(dev_absent_i), .step_div_i(step_div_i), .sclk_o(sclk_o),
    .sdo_o(sdo_o), .sdi_i(sdi_i), .grant_hi_o(grant_hi_o), .grant_lo_o(grant_lo_o),
    .m_valid_o(m_valid_o), .m_data_o(m_data_o), .m_ready_i(m_ready_i),
    .busy_o(busy_o), .error_o(error_o)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  function automatic logic [7:0] memb(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  // device model and pin-order monitor
  always @(posedge grant_hi_o) if (rst_n) begin
    rise_cnt = 0; hi_rises++;
    if (!grant_lo_o) viol++;
  end
  always @(negedge grant_lo_o) if (rst_n && !grant_hi_o) viol++;
  always @(posedge grant_lo_o) if (rst_n && !grant_hi_o) viol++;
  always @(negedge grant_hi_o) if (rst_n && !grant_lo_o) viol++;
  always @(negedge sclk_o) if (rst_n && rise_cnt <= 24 && sdo_o != sdo_at_rise) viol4++;
  always @(posedge sclk_o) if (rst_n) begin
    if (!(grant_hi_o && !grant_lo_o)) viol++;
    if (rise_cnt < 24) begin
      cap = {cap[22:0], sdo_o};
      sdo_at_rise = sdo_o;
    end else begin
      int k;
      logic [7:0] b;
      k = rise_cnt - 24;
      b = memb(cap[15:0] + 16'(k / 8));
      sdi_i = b[7 - (k % 8)];
    end
    if (rise_cnt == 0)  t_r0 = cyc;
    if (rise_cnt == 1)  t_r1 = cyc;
    if (rise_cnt == 24) t_r24 = cyc;
    if (rise_cnt == 25) t_r25 = cyc;
    rise_cnt++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_xfer(input logic [31:0] base, input logic [15:0] off, input int cnt,
                          input int div, input int mode, input bit inject);
    int guard = 0, stall_n = 0, r0 = 0;
    logic [7:0] d0 = '0;
    base_i = base; step_div_i = DIV_W'(div); nbytes = 0;
    @(negedge clk);
    offset_i = off; count_i = CNT_W'(cnt); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (busy_o || m_valid_o) begin
      guard++;
      if (guard > 20000) begin
        check(1'b0, "R10 transfer never finished", guard, 0);
        break;
      end
      if (inject && guard == 30) begin
        start_i = 1'b1; offset_i = ~off; count_i = CNT_W'(1);
      end
      if (inject && guard == 31) start_i = 1'b0;
      if (mode == 2 && m_valid_o && stall_n < 40) begin
        if (stall_n == 0) begin d0 = m_data_o; r0 = rise_cnt; end
        m_ready_i = 1'b0;
        stall_n++;
        if (stall_n == 40)
          check(m_valid_o && m_data_o == d0 && rise_cnt == r0, "R8 byte held under stall",
                rise_cnt, r0);
      end else begin
        m_ready_i = (mode == 1) ? (guard % 3 == 0) : 1'b1;
      end
      if (m_valid_o && m_ready_i && nbytes < 16) begin
        rx_bytes[nbytes] = m_data_o;
        nbytes++;
      end
      @(negedge clk);
    end
    m_ready_i = 1'b0;
  endtask

  task automatic verify(input logic [31:0] base, input logic [15:0] off, input int cnt, input int div);
    logic [15:0] a;
    int n;
    a = base[15:0] + off;
    n = div + 1;
    check(cap[23:16] == 8'h03, "R5 command byte", cap[23:16], 3);
    check(cap[15:0] == a, "R5 address bytes", cap[15:0], a);
    check(nbytes == cnt, "R9 delivered count", nbytes, cnt);
    for (int i = 0; i < nbytes && i < cnt; i++)
      check(rx_bytes[i] == memb(a + 16'(i)), "R6 received byte", rx_bytes[i], memb(a + 16'(i)));
    check(t_r1 - t_r0 == 3 * n, "R7 outgoing bit period", t_r1 - t_r0, 3 * n);
    if (cnt > 0) check(t_r25 - t_r24 == 2 * n, "R7 incoming bit period", t_r25 - t_r24, 2 * n);
    check(viol == 0, "R2 R3 grant and clock ordering", viol, 0);
    check(viol4 == 0, "R4 data steady under clock", viol4, 0);
    check(!busy_o && !grant_hi_o && grant_lo_o && !sclk_o, "R10 released when idle",
          {busy_o, grant_hi_o, grant_lo_o, sclk_o}, 4'b0010);
  endtask

  task automatic try_fault(input logic pres, input logic absent, input logic [31:0] base, input string what);
    int h;
    h = hi_rises;
    dev_present_i = pres; dev_absent_i = absent; base_i = base;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (20) @(negedge clk);
    check(error_o && !busy_o && hi_rises == h, what, {error_o, busy_o}, 2'b10);
    dev_present_i = 1'b1; dev_absent_i = 1'b0; base_i = '0;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL R10 watchdog expired actual=%0d expected=0", cyc);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!sclk_o && !grant_hi_o && grant_lo_o && !busy_o && !error_o && !m_valid_o,
          "R1 reset state", {sclk_o, grant_hi_o, grant_lo_o, busy_o, error_o, m_valid_o}, 6'b001000);

    for (int v = 0; v < NV; v++) begin
      run_xfer(V_BASE[v], V_OFF[v], V_CNT[v], V_DIV[v], V_MODE[v], 1'b0);
      verify(V_BASE[v], V_OFF[v], V_CNT[v], V_DIV[v]);
    end

    // R9 zero-length request
    run_xfer(32'h20, 16'h0040, 0, 1, 0, 1'b0);
    verify(32'h20, 16'h0040, 0, 1);

    // R8 consumer stall
    run_xfer(32'h0, 16'h0300, 3, 0, 2, 1'b0);
    verify(32'h0, 16'h0300, 3, 0);

    // R11 start while busy
    run_xfer(32'h100, 16'h0010, 2, 0, 0, 1'b1);
    verify(32'h100, 16'h0010, 2, 0);
    check(!busy_o, "R11 no second transfer started", busy_o, 0);

    // R12 refused starts
    try_fault(1'b0, 1'b0, 32'h0, "R12 refused: device not present");
    try_fault(1'b1, 1'b1, 32'h0, "R12 refused: absent indication");
    try_fault(1'b1, 1'b0, 32'h0001_0000, "R12 refused: base above 0xFFFF");
    run_xfer(32'h0, 16'h0007, 1, 0, 0, 1'b0);
    verify(32'h0, 16'h0007, 1, 0);
    check(!error_o, "R12 error cleared by accepted start", error_o, 0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule